// File: doc/BRIEF.md
# Bidirectional latch/register bus transceiver

This block sits between two 18-bit buses, called A and B, and carries data across them in both directions. Each direction has its own storage element and its own three controls: an output enable, a latch enable and a path clock. With the latch enable high, a path is transparent and its output follows its input. With the latch enable low, the path keeps its stored word while its clock stays at one level, and loads a new word when its clock goes from high to low.

The block is synchronous to a system clock `clk`. Both path clocks are sampled on rising edges of `clk`, and a high-to-low change between two samples counts as a capture event. The bus ports are given as separate input, output and drive-enable signals. An output enable that is low means the port is released (high-impedance). If both directions drive at once, a contention flag is raised. The A-to-B enable is active high. The B-to-A enable is active low by default, and a parameter sets its polarity.

Top module: `bus_xcvr18`

## Requirements
- R1: While `ab_le` is 1, `b_out` equals `a_in` in the same cycle. The stored word follows `a_in` at every rising `clk` edge, so after `ab_le` falls, `b_out` keeps the value `a_in` had at the last such edge.
- R2: While `ab_le` is 0 and `ab_clk` stays constant (either 1 or 0), `b_out` does not change, whatever `a_in` does.
- R3: While `ab_le` is 0, if `ab_clk` is seen as 1 at one rising `clk` edge and as 0 at the next, then `a_in` is stored at that second edge and appears on `b_out` just after it. A change of `ab_clk` from 0 to 1 stores nothing.
- R4: `b_oe` is 0 whenever `ab_oe` is 0 (active-high enable). An armed path drives (`b_oe` = 1) as soon as `ab_oe` is 1.
- R5: The B-to-A path behaves like R1 to R3: `b_in` goes to `a_out`, controlled by `ba_le` and `ba_clk`.
- R6: With the default polarity (`BA_OE_HIGH` = 0), `a_oe` is 1 only while `ba_oe` is 0 and the path is armed. `ba_oe` = 1 releases the A port.
- R7: Reset (`rst_n` = 0) is asynchronous. It clears both stored words to 0 and disarms both enables. A disarmed path keeps its drive signal at 0 until its enable input has been seen inactive at a rising `clk` edge. After that, the drive signal follows the enable input.
- R8: `contention` is 1 exactly when `a_oe` and `b_oe` are both 1.
- R9: Activity on one path leaves the other path's output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; path clocks are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 18 | Value seen on the A bus |
| a_out | output | 18 | Value the block drives onto the A bus |
| a_oe | output | 1 | 1 = block drives the A bus; 0 = A bus released |
| b_in | input | 18 | Value seen on the B bus |
| b_out | output | 18 | Value the block drives onto the B bus |
| b_oe | output | 1 | 1 = block drives the B bus; 0 = B bus released |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ab_le | input | 1 | A-to-B latch enable; 1 = transparent |
| ab_clk | input | 1 | A-to-B path clock; stores on a high-to-low change |
| ba_oe | input | 1 | B-to-A output enable, active low by default |
| ba_le | input | 1 | B-to-A latch enable; 1 = transparent |
| ba_clk | input | 1 | B-to-A path clock; stores on a high-to-low change |
| contention | output | 1 | Both directions drive at the same time |

## Verification
The hardest case to reach from the ports is the gap between a falling path clock and a rising one, seen while the latch enable is low. The stimulus drives `ab_clk` up and down with fresh data at each step and keeps the latch closed. A store on the wrong edge therefore shows up as a changed output. A second hard case is an enable held active all through reset. The bench holds both enables active across reset, checks that neither port drives, and then releases and re-asserts each enable to arm it.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic [1:0] {
        PM_HOLD    = 2'd0,
        PM_PASS    = 2'd1,
        PM_CAPTURE = 2'd2
    } path_mode_e;

    function automatic logic oe_active(input logic oe, input bit active_high);
        return (oe == active_high);
    endfunction

endpackage

// File: rtl/xcvr_fall_det.sv
module xcvr_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic fall
);
    logic lvl_d, lvl_q;

    always_comb begin
        lvl_d = lvl;
        fall  = lvl_q & ~lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_d;
    end
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
    import xcvr_pkg::*;
#(
    parameter int W       = 18,
    parameter bit OE_HIGH = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         le,
    input  logic         pclk,
    input  logic         oe,
    output logic [W-1:0] dout,
    output logic         drive
);
    typedef struct packed {
        logic [W-1:0] store;
        logic         armed;
    } path_st_t;

    path_st_t   st_d, st_q;
    logic       fall;
    logic       en_act;
    path_mode_e mode;

    xcvr_fall_det u_fall (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (pclk),
        .fall (fall)
    );

    always_comb begin
        st_d   = st_q;
        en_act = oe_active(oe, OE_HIGH);
        mode   = PM_HOLD;
        if (!en_act) st_d.armed = 1'b1;
        if (le) begin
            mode       = PM_PASS;
            st_d.store = din;
        end else if (fall) begin
            mode       = PM_CAPTURE;
            st_d.store = din;
        end
        dout  = (mode == PM_PASS) ? din : st_q.store;
        drive = st_q.armed & en_act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1: the word passed while transparent is the one kept when the latch closes
    assert_track_R1: assert property (@(posedge clk) disable iff (!rst_n)
        le |=> (le || dout == $past(din)));

    // R2: closed latch with no falling path clock keeps the output steady
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && !fall) |=> (le || $stable(dout)));

    // R3: a falling path clock stores the input seen at that edge
    assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && fall) |=> (le || dout == $past(din)));
endmodule

// File: rtl/bus_xcvr18.sv
module bus_xcvr18 #(
    parameter int W          = 18,
    parameter bit AB_OE_HIGH = 1'b1,
    parameter bit BA_OE_HIGH = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    input  logic         ab_oe,
    input  logic         ab_le,
    input  logic         ab_clk,
    input  logic         ba_oe,
    input  logic         ba_le,
    input  logic         ba_clk,
    output logic         contention
);
    localparam int NDIR = 2;

    logic [NDIR-1:0][W-1:0] p_din, p_dout;
    logic [NDIR-1:0]        p_le, p_clk, p_oe, p_drive;

    assign p_din[0] = a_in;
    assign p_le[0]  = ab_le;
    assign p_clk[0] = ab_clk;
    assign p_oe[0]  = ab_oe;
    assign p_din[1] = b_in;
    assign p_le[1]  = ba_le;
    assign p_clk[1] = ba_clk;
    assign p_oe[1]  = ba_oe;

    for (genvar gi = 0; gi < NDIR; gi++) begin : g_dir
        xcvr_path #(
            .W      (W),
            .OE_HIGH(gi == 0 ? AB_OE_HIGH : BA_OE_HIGH)
        ) u_path (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (p_din[gi]),
            .le   (p_le[gi]),
            .pclk (p_clk[gi]),
            .oe   (p_oe[gi]),
            .dout (p_dout[gi]),
            .drive(p_drive[gi])
        );
    end

    assign b_out      = p_dout[0];
    assign b_oe       = p_drive[0];
    assign a_out      = p_dout[1];
    assign a_oe       = p_drive[1];
    assign contention = p_drive[0] & p_drive[1];

    // R4: an inactive A-to-B enable never lets the B port drive
    assert_b_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_oe != AB_OE_HIGH) |-> !b_oe);

    // R6: an inactive B-to-A enable never lets the A port drive
    assert_a_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ba_oe != BA_OE_HIGH) |-> !a_oe);

    // R8: contention only arises when both enable inputs are active
    assert_contention_R8: assert property (@(posedge clk) disable iff (!rst_n)
        contention |-> (ab_oe == AB_OE_HIGH && ba_oe == BA_OE_HIGH));
endmodule

// File: tb/tb_bus_xcvr18.sv
module tb_bus_xcvr18;
    localparam int W  = 18;
    localparam int NV = 13;

    typedef struct packed {
        logic         le;
        logic         pc;
        logic [W-1:0] d;
        logic [W-1:0] e;
    } vec_t;

    // le, path clock, data in, expected out (sampled just after each clk edge)
    localparam vec_t VECS [NV] = '{
        {1'b1, 1'b0, 18'h12345, 18'h12345},
        {1'b1, 1'b0, 18'h2AAAA, 18'h2AAAA},
        {1'b0, 1'b0, 18'h3FFFF, 18'h2AAAA},
        {1'b0, 1'b1, 18'h15555, 18'h2AAAA},
        {1'b0, 1'b1, 18'h00F0F, 18'h2AAAA},
        {1'b0, 1'b0, 18'h0BEEF, 18'h0BEEF},
        {1'b0, 1'b0, 18'h31337, 18'h0BEEF},
        {1'b0, 1'b1, 18'h00001, 18'h0BEEF},
        {1'b0, 1'b0, 18'h20000, 18'h20000},
        {1'b1, 1'b0, 18'h3C3C3, 18'h3C3C3},
        {1'b1, 1'b1, 18'h0FF00, 18'h0FF00},
        {1'b0, 1'b0, 18'h12121, 18'h12121},
        {1'b0, 1'b0, 18'h3FFFF, 18'h12121}
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] a_in, b_in, a_out, b_out;
    logic         a_oe, b_oe, contention;
    logic         ab_oe, ab_le, ab_clk, ba_oe, ba_le, ba_clk;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    bus_xcvr18 dut (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .ab_oe(ab_oe), .ab_le(ab_le), .ab_clk(ab_clk),
        .ba_oe(ba_oe), .ba_le(ba_le), .ba_clk(ba_clk),
        .contention(contention)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_table(input bit dir);
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            if (!dir) begin
                ab_le = VECS[i].le; ab_clk = VECS[i].pc; a_in = VECS[i].d;
            end else begin
                ba_le = VECS[i].le; ba_clk = VECS[i].pc; b_in = VECS[i].d;
            end
            @(posedge clk);
            #5;
            if (!dir) begin
                chk($sformatf("R1 R2 R3 A-to-B vector %0d", i), b_out, VECS[i].e);
            end else begin
                chk($sformatf("R5 B-to-A vector %0d", i), a_out, VECS[i].e);
                chk($sformatf("R9 B port unchanged, vector %0d", i), b_out, 18'h12121);
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion (all requirements)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        a_in = '0; b_in = '0;
        ab_le = 1'b0; ab_clk = 1'b0; ba_le = 1'b0; ba_clk = 1'b0;
        ab_oe = 1'b1;   // active through reset
        ba_oe = 1'b0;   // active (low) through reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R7 b_out cleared", b_out, 0);
        chk("R7 a_out cleared", a_out, 0);
        chk("R7 b_oe disarmed", b_oe, 0);
        chk("R7 a_oe disarmed", a_oe, 0);
        @(posedge clk); #5;
        chk("R7 b_oe stays off while enable held", b_oe, 0);
        chk("R7 a_oe stays off while enable held", a_oe, 0);
        chk("R8 no contention when disarmed", contention, 0);

        @(negedge clk);
        ab_oe = 1'b0; ba_oe = 1'b1;
        @(posedge clk); #5;
        chk("R4 b_oe off with ab_oe=0", b_oe, 0);
        @(negedge clk);
        ab_oe = 1'b1;
        #1;
        chk("R4 b_oe on after arming", b_oe, 1);
        chk("R6 a_oe off with ba_oe=1", a_oe, 0);

        run_table(1'b0);

        @(negedge clk);
        ab_oe = 1'b0;
        #1;
        chk("R4 b_oe released", b_oe, 0);
        ba_oe = 1'b0;
        #1;
        chk("R6 a_oe on with ba_oe=0", a_oe, 1);
        chk("R8 no contention single driver", contention, 0);

        run_table(1'b1);

        @(negedge clk);
        ab_oe = 1'b1;
        #1;
        chk("R8 contention both driving", contention, 1);
        ba_oe = 1'b1;
        #1;
        chk("R6 a_oe released", a_oe, 0);
        chk("R8 contention cleared", contention, 0);

        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R7 mid-run reset b_out", b_out, 0);
        chk("R7 mid-run reset a_out", a_out, 0);
        chk("R7 mid-run reset b_oe", b_oe, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule